// File: doc/BRIEF.md
# Configurable Audio Serial Transmitter

This block drives a serial audio link as the clock source. It takes a left and a right sample through a valid/ready pair, divides the system clock down to a bit clock, and shifts each sample out MSB first on one data line. Next to the data it drives a word-select line, which is either a channel clock or a frame pulse. A frame holds two slots (a stereo pair) or eight time-division slots.

The protocol is set by a small configuration register: standard I2S with its one-bit lead, left- or right-justified, or PCM/DSP with a programmable frame pulse width. The same register sets the slot and data widths and a mono option. The register accepts writes only while the block is disabled. Clearing the enable input stops the bit clock and returns every output to idle. If no sample is waiting when a pair of slots begins, the block fills that pair with zeros and sets a sticky underrun flag.

Top module: `audio_ser_tx`

## Requirements
- R1: While `rst` is high or `en` is low, `bclk`, `lrclk`, `sdata`, `s_ready` and `underrun` are 0 from the next clock edge on (`s_ready` at once).
- R2: The bit clock period is 2*(`cfg_hdiv`+1) system clocks with equal high and low halves, and it starts low. `sdata` and `lrclk` change only at the edge where `bclk` falls, so a receiver samples on the rising edge.
- R3: Word-length code `cfg_wlen` selects: 0 = 16 data bits in a 16-bit slot, 1 = 16 in 32, 2 = 32 in 32, 3 = 24 in 32. Samples are taken from the low bits of the 32-bit inputs, and slot bits not carrying data are 0.
- R4: Data leaves MSB first. In standard I2S (`cfg_proto`=0, and the spare code 2 behaves the same), in PCM (`cfg_proto`=3), and in justified mode with `cfg_rjust`=0, the MSB is the first bit of the slot.
- R5: In justified mode (`cfg_proto`=1) with `cfg_rjust`=1, the data is preceded by zeros so that its LSB is the last bit of the slot.
- R6: In standard I2S, `lrclk` leads the slot grid by one bit clock. With two slots it is 0 one bit before and through the left slot, and 1 for the right slot. With eight slots it is a one-bit pulse on the last bit of the frame.
- R7: In justified mode, `lrclk` is aligned with the first data bit. With two slots it is 0 during slot 0 and 1 during slot 1. With eight slots it is a one-bit pulse on frame bit 0.
- R8: In PCM mode, `lrclk` is high for `cfg_fsw`+1 bit clocks starting at frame bit 0, for either frame size.
- R9: Slot count is 2 when `cfg_tdm`=0 and 8 when it is 1. One sample is accepted (`s_ready` and `s_valid` both high) at the start of every even slot. Slot 2k carries its left word and slot 2k+1 its right word.
- R10: With `cfg_mono`=1, the left word is sent in both slots of the pair and `s_right` is ignored.
- R11: If `s_valid` is low when a pair starts, both slots of that pair are all zeros and `underrun` goes to 1. It stays at 1 until `en` is cleared.
- R12: The configuration fields reset to 0, which selects standard I2S, two slots, 16/16, stereo and a divide of 2. `cfg_we` takes effect only while `en` is 0, so a write made during a run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low stops and idles the link |
| cfg_we | input | 1 | Configuration write strobe (honoured while en is low) |
| cfg_proto | input | 2 | 0 standard I2S, 1 justified, 2 spare (as 0), 3 PCM/DSP |
| cfg_rjust | input | 1 | In justified mode: 1 right-justified, 0 left-justified |
| cfg_tdm | input | 1 | 0 two slots per frame, 1 eight slots |
| cfg_wlen | input | 2 | Data/slot width code |
| cfg_mono | input | 1 | 1 repeats the left word in the right slot |
| cfg_fsw | input | FSW_W | PCM frame pulse width minus one, in bit clocks |
| cfg_hdiv | input | DIV_W | Bit-clock half period minus one, in system clocks |
| s_valid | input | 1 | Sample pair available |
| s_ready | output | 1 | Sample pair accepted this cycle |
| s_left | input | 32 | Left sample, LSB-aligned |
| s_right | input | 32 | Right sample, LSB-aligned |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Channel clock or frame pulse |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | Sticky: a pair began with no sample |

## Verification
A fault in the single position counter puts the next frame marker on `lrclk` in the wrong place, or splits the data at the wrong bit. This becomes visible within one frame, at most 256 bit clocks. A wrong bit index or a wrong width decode corrupts the serial word in its first slot. A wrong handshake timing moves samples into the wrong slot or repeats them, which shows in the second pair. A fault in the configuration lock or the underrun latch shows as soon as a run has its settings changed, or recovers from starvation, because the frame or the flag then differs at once.

// File: rtl/audio_ser_tx_pkg.sv
package audio_ser_tx_pkg;
  localparam int SAMPLE_W = 32;

  typedef enum logic [1:0] {
    PROTO_I2S  = 2'b00,
    PROTO_JUST = 2'b01,
    PROTO_SPR  = 2'b10,
    PROTO_PCM  = 2'b11
  } proto_e;

  typedef struct packed {
    proto_e     proto;
    logic       rjust;
    logic       tdm;
    logic [1:0] wlen;
    logic       mono;
  } link_cfg_t;
endpackage

// File: rtl/ast_bitclk.sv
module ast_bitclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_m1,
  output logic             bclk,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick = run && (cnt == half_m1);
  assign fall = tick && bclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (tick) begin
      cnt  <= '0;
      bclk <= ~bclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ast_slotseq.sv
module ast_slotseq
  import audio_ser_tx_pkg::*;
#(
  parameter int POS_W     = 8,
  parameter int FSW_W     = 3,
  parameter int TDM_SLOTS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             step,
  input  proto_e           proto,
  input  logic             tdm,
  input  logic             long32,
  input  logic [FSW_W-1:0] fsw,
  output logic [4:0]       bit_idx,
  output logic             odd_slot,
  output logic             take,
  output logic             lr_next
);
  logic [POS_W-1:0] pos, last, nxt, q;
  logic             lead;

  assign last     = POS_W'((tdm ? TDM_SLOTS : 2) * (long32 ? 32 : 16) - 1);
  assign nxt      = (pos == last) ? '0 : pos + 1'b1;
  assign lead     = (proto == PROTO_I2S) || (proto == PROTO_SPR);
  assign q        = lead ? nxt : pos;
  assign bit_idx  = long32 ? pos[4:0] : {1'b0, pos[3:0]};
  assign odd_slot = long32 ? pos[5] : pos[4];
  assign take     = step && (bit_idx == 5'd0) && !odd_slot;

  always_comb begin
    if (proto == PROTO_PCM)
      lr_next = (pos <= {{(POS_W-FSW_W){1'b0}}, fsw});
    else if (tdm)
      lr_next = (q == '0);
    else
      lr_next = long32 ? q[5] : q[4];
  end

  always_ff @(posedge clk) begin
    if (rst || !run) pos <= '0;
    else if (step)   pos <= nxt;
  end
endmodule

// File: rtl/ast_serializer.sv
module ast_serializer
  import audio_ser_tx_pkg::*;
(
  input  logic [SAMPLE_W-1:0] word,
  input  logic [4:0]          bit_idx,
  input  logic [1:0]          wlen,
  input  logic                rj,
  output logic                bit_out
);
  logic [5:0] sl, dl, pad, bb;
  logic [4:0] idx;
  logic       on;

  always_comb begin
    sl = (wlen == 2'd0) ? 6'd16 : 6'd32;
    case (wlen)
      2'd2:    dl = 6'd32;
      2'd3:    dl = 6'd24;
      default: dl = 6'd16;
    endcase
    pad = sl - dl;
    bb  = {1'b0, bit_idx};
    if (rj) begin
      on  = (bb >= pad);
      idx = 5'(sl - 6'd1 - bb);
    end else begin
      on  = (bb < dl);
      idx = 5'(dl - 6'd1 - bb);
    end
    bit_out = on && word[idx];
  end
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
  import audio_ser_tx_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int FSW_W     = 3,
  parameter int TDM_SLOTS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_proto,
  input  logic                cfg_rjust,
  input  logic                cfg_tdm,
  input  logic [1:0]          cfg_wlen,
  input  logic                cfg_mono,
  input  logic [FSW_W-1:0]    cfg_fsw,
  input  logic [DIV_W-1:0]    cfg_hdiv,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  output logic                bclk,
  output logic                lrclk,
  output logic                sdata,
  output logic                underrun
);
  localparam int POS_W = $clog2(TDM_SLOTS * 32);

  link_cfg_t           cfg;
  logic [FSW_W-1:0]    fsw_q;
  logic [DIV_W-1:0]    hdiv_q;
  logic [SAMPLE_W-1:0] lw, rw, new_l, new_r, cur;
  logic                fall, take, odd_slot, lr_next, bit_n;
  logic [4:0]          bit_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg    <= '0;
      fsw_q  <= '0;
      hdiv_q <= '0;
    end else if (cfg_we && !en) begin
      cfg    <= '{proto: proto_e'(cfg_proto), rjust: cfg_rjust, tdm: cfg_tdm,
                  wlen: cfg_wlen, mono: cfg_mono};
      fsw_q  <= cfg_fsw;
      hdiv_q <= cfg_hdiv;
    end
  end

  ast_bitclk #(.DIV_W(DIV_W)) clk_i (
    .clk(clk), .rst(rst), .run(en), .half_m1(hdiv_q), .bclk(bclk), .fall(fall)
  );

  ast_slotseq #(.POS_W(POS_W), .FSW_W(FSW_W), .TDM_SLOTS(TDM_SLOTS)) seq_i (
    .clk(clk), .rst(rst), .run(en), .step(fall), .proto(cfg.proto),
    .tdm(cfg.tdm), .long32(cfg.wlen != 2'd0), .fsw(fsw_q),
    .bit_idx(bit_idx), .odd_slot(odd_slot), .take(take), .lr_next(lr_next)
  );

  assign s_ready = take;
  assign new_l   = s_valid ? s_left : '0;
  assign new_r   = !s_valid ? '0 : (cfg.mono ? s_left : s_right);
  assign cur     = odd_slot ? rw : (take ? new_l : lw);

  ast_serializer ser_i (
    .word(cur), .bit_idx(bit_idx), .wlen(cfg.wlen),
    .rj((cfg.proto == PROTO_JUST) && cfg.rjust), .bit_out(bit_n)
  );

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sdata    <= 1'b0;
      lrclk    <= 1'b0;
      lw       <= '0;
      rw       <= '0;
      underrun <= 1'b0;
    end else if (fall) begin
      sdata <= bit_n;
      lrclk <= lr_next;
      if (take) begin
        lw <= new_l;
        rw <= new_r;
        if (!s_valid) underrun <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic bclk,
  input logic lrclk,
  input logic sdata,
  input logic s_ready,
  input logic underrun
);
  p_idle_outs_r1: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!bclk && !lrclk && !sdata && !underrun));

  p_idle_ready_r1: assert property (@(posedge clk) disable iff (rst)
    !en |-> !s_ready);

  p_sdata_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && (sdata != $past(sdata))) |-> $fell(bclk));

  p_lr_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && (lrclk != $past(lrclk))) |-> $fell(bclk));

  p_take_at_fall_r9: assert property (@(posedge clk) disable iff (rst)
    (s_ready && en) |=> $fell(bclk));

  p_underrun_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && $past(underrun)) |-> underrun);
endmodule

bind audio_ser_tx audio_ser_tx_chk chk_i (
  .clk(clk), .rst(rst), .en(en), .bclk(bclk), .lrclk(lrclk),
  .sdata(sdata), .s_ready(s_ready), .underrun(underrun)
);

// File: tb/audio_ser_tx_tb_top.sv
module audio_ser_tx_tb_top;
  logic clk = 1'b0, rst = 1'b1, en = 1'b0, cfg_we = 1'b0;
  logic [1:0] cfg_proto = '0, cfg_wlen = '0;
  logic cfg_rjust = 1'b0, cfg_tdm = 1'b0, cfg_mono = 1'b0;
  logic [2:0] cfg_fsw = '0;
  logic [7:0] cfg_hdiv = '0;
  logic s_valid, s_ready, bclk, lrclk, sdata, underrun;
  logic [31:0] s_left, s_right;

  logic [31:0] lm [16];
  logic [31:0] rm [16];
  int fidx = 0;
  logic starve = 1'b0;
  logic capturing = 1'b0, bclk_q = 1'b0;
  int nrise = 0, ncap = 0;
  logic rsd [600];
  logic rlr [600];
  int ntot = 0, nbad = 0;
  logic done = 1'b0;
  // expected configuration held by the bench
  int e_v = 0, e_tdm = 0, e_wl = 0, e_mono = 0, e_fsw = 0;

  always #4 clk = ~clk;

  assign s_valid = !starve;
  assign s_left  = lm[fidx];
  assign s_right = rm[fidx];

  audio_ser_tx dut_i (
    .clk(clk), .rst(rst), .en(en), .cfg_we(cfg_we), .cfg_proto(cfg_proto),
    .cfg_rjust(cfg_rjust), .cfg_tdm(cfg_tdm), .cfg_wlen(cfg_wlen),
    .cfg_mono(cfg_mono), .cfg_fsw(cfg_fsw), .cfg_hdiv(cfg_hdiv),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .bclk(bclk), .lrclk(lrclk), .sdata(sdata), .underrun(underrun)
  );

  always @(posedge clk) begin
    if (!en) fidx <= 0;
    else if (s_valid && s_ready) fidx <= fidx + 1;
  end

  always @(negedge clk) begin
    if (!capturing) begin
      nrise = 0;
      ncap  = 0;
    end else if (bclk && !bclk_q) begin
      nrise++;
      if (nrise >= 2 && ncap < 600) begin
        rsd[ncap] = sdata;
        rlr[ncap] = lrclk;
        ncap++;
      end
    end
    bclk_q = bclk;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    ntot++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int slen();
    return (e_wl == 0) ? 16 : 32;
  endfunction

  function automatic int flen();
    return (e_tdm != 0 ? 8 : 2) * slen();
  endfunction

  function automatic logic exp_sd(input int p);
    int sl, dl, b, g, pr;
    logic [31:0] w;
    sl = slen();
    dl = (e_wl == 2) ? 32 : (e_wl == 3) ? 24 : 16;
    b = p % sl; g = p / sl; pr = g / 2;
    if (starve) return 1'b0;
    w = ((g % 2) == 0 || e_mono != 0) ? lm[pr] : rm[pr];
    if (e_v == 2) return (b >= sl - dl) ? w[sl-1-b] : 1'b0;
    return (b < dl) ? w[dl-1-b] : 1'b0;
  endfunction

  function automatic logic exp_lr(input int p);
    int f, pf, q;
    f = flen(); pf = p % f;
    if (e_v == 3) return pf <= e_fsw;
    q = (e_v == 0) ? (pf + 1) % f : pf;
    if (e_tdm != 0) return q == 0;
    return ((q / slen()) % 2) == 1;
  endfunction

  // variants: 0 std I2S, 1 left-justified, 2 right-justified, 3 PCM
  task automatic set_cfg(input int v, input int tdm, input int wl, input int mono,
                         input int fsw, input int hdiv);
    cfg_proto = (v == 3) ? 2'd3 : (v == 0) ? 2'd0 : 2'd1;
    cfg_rjust = (v == 2);
    cfg_tdm   = tdm[0];
    cfg_wlen  = wl[1:0];
    cfg_mono  = mono[0];
    cfg_fsw   = fsw[2:0];
    cfg_hdiv  = hdiv[7:0];
    cfg_we    = 1'b1;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic capture_run(input int seed, input bit poke);
    int need, em_d, em_l;
    for (int j = 0; j < 16; j++) begin
      lm[j] = (32'h9E37_79B9 * (j + 1)) ^ (seed * 32'h0101_0203);
      rm[j] = ~lm[j] ^ (32'h2468_ACE1 + j);
    end
    need = 2 * flen();
    capturing = 1'b1;
    en = 1'b1;
    if (poke) begin
      repeat (10) @(negedge clk);
      set_cfg(3, 1, 2, 1, 5, 4);
    end
    while (ncap < need) @(negedge clk);
    em_d = 0; em_l = 0;
    for (int p = 0; p < need; p++) begin
      if (rsd[p] !== exp_sd(p)) em_d++;
      if (rlr[p] !== exp_lr(p)) em_l++;
    end
    if (poke) begin
      chk(em_d == 0, "R12 data after write during run", em_d, 0);
      chk(em_l == 0, "R12 lrclk after write during run", em_l, 0);
    end else begin
      chk(em_d == 0, $sformatf("R3 R4 R5 R9 R10 data v%0d t%0d w%0d m%0d", e_v, e_tdm, e_wl, e_mono), em_d, 0);
      chk(em_l == 0, $sformatf("R6 R7 R8 lrclk v%0d t%0d w%0d m%0d", e_v, e_tdm, e_wl, e_mono), em_l, 0);
    end
  endtask

  task automatic stop_run();
    @(negedge clk);
    en = 1'b0;
    capturing = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nbad++; ntot++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end

  initial begin
    int t0, t1, t2, n;
    repeat (3) @(negedge clk);
    chk({bclk, lrclk, sdata, s_ready, underrun} == 5'd0, "R1 outputs in reset",
        {bclk, lrclk, sdata, s_ready, underrun}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk({bclk, lrclk, sdata, s_ready, underrun} == 5'd0, "R1 outputs while disabled",
        {bclk, lrclk, sdata, s_ready, underrun}, 0);

    // R12 reset defaults: enable without any write
    capture_run(99, 1'b0);
    stop_run();
    chk({bclk, lrclk, sdata, underrun} == 4'd0, "R1 idle after disable",
        {bclk, lrclk, sdata, underrun}, 0);

    // sweep of protocol variant, frame size, width and mono
    n = 0;
    for (int v = 0; v < 4; v++)
      for (int t = 0; t < 2; t++)
        for (int w = 0; w < 4; w++)
          for (int m = 0; m < 2; m++) begin
            e_v = v; e_tdm = t; e_wl = w; e_mono = m; e_fsw = n % 8;
            set_cfg(v, t, w, m, e_fsw, 0);
            capture_run(n, 1'b0);
            stop_run();
            n++;
          end

    // R12 configuration write while running is ignored
    e_v = 1; e_tdm = 0; e_wl = 1; e_mono = 0; e_fsw = 0;
    set_cfg(1, 0, 1, 0, 0, 0);
    capture_run(7, 1'b1);
    stop_run();

    // R2 divider: half period 3 system clocks
    set_cfg(0, 0, 0, 0, 0, 2);
    en = 1'b1;
    t0 = 0; t1 = 0; t2 = 0;
    while (!bclk) begin @(negedge clk); t0++; end
    while (bclk)  begin @(negedge clk); t1++; end
    while (!bclk) begin @(negedge clk); t2++; end
    chk(t1 == 3, "R2 bclk high time", t1, 3);
    chk(t2 == 3, "R2 bclk low time", t2, 3);
    chk(t0 == 3, "R2 first rise delay", t0, 3);
    stop_run();

    // R11 underrun: starved stream is all zero and flag is sticky
    e_v = 0; e_tdm = 0; e_wl = 0; e_mono = 0; e_fsw = 0;
    set_cfg(0, 0, 0, 0, 0, 0);
    starve = 1'b1;
    capture_run(3, 1'b0);
    chk(underrun == 1'b1, "R11 underrun set", underrun, 1);
    starve = 1'b0;
    repeat (200) @(negedge clk);
    chk(underrun == 1'b1, "R11 underrun sticky after recovery", underrun, 1);
    stop_run();
    chk(underrun == 1'b0, "R11 underrun cleared by disable", underrun, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule